// File: doc/BRIEF.md
# Parallel Flash Command-State Controller

This block models the command interface of a parallel NOR flash device that follows the common command set. It sits behind a simple synchronous bus made of chip select, write enable, an address, an 8-bit write byte and an 8-bit read byte. Bus writes are taken as command bytes. Bus reads return one of three sources, chosen by the held command: the array contents, the status register or the query table. The array contents are a fixed pattern computed from the address, because real storage, programming and erase are not modelled.

The block holds three pieces of state: the current command byte, a write-cycle counter and an 8-bit status register. It also keeps one lock bit for each block. Every failed, aborted or unknown command returns the block to array reads. None of these fallbacks clears the status error bits. Only the clear-status command or a device reset clears them. A two-cycle lock/unlock sequence sets or clears the lock bit of the block that the confirm cycle addresses, and it marks the status register ready.

Top module: `pflash_cmd_ctrl`

## Requirements
- R1: After reset, the held command is read-array (0xFF), the status register reads 0x00, all lock bits are 0, and reads return array bytes.
- R2: In read-array mode, a read at address A returns (A*37 + 11) mod 256.
- R3: A first-cycle write of 0xFF or of 0xF0 selects read-array mode and leaves the status register unchanged.
- R4: A first-cycle write of 0x70 selects status reads. Reads then return the status byte: bit 7 is ready, bit 5 is lock-sequence error, bit 4 is command error, and all other bits are 0.
- R5: A first-cycle write of 0x50 clears the status register to 0x00 and then selects read-array mode.
- R6: A first-cycle write of 0x60 arms a second cycle. A confirm of 0x01 locks the block given by address bits [9:8] of the confirm cycle, and a confirm of 0xD0 unlocks it. Either confirm sets status bit 7, returns the cycle counter to zero and leaves reads returning status.
- R7: On the second cycle of the lock sequence, 0xFF returns to read-array mode with no error. Any other byte besides 0x01 and 0xD0 sets status bit 5 and returns to read-array mode. In neither case does any lock bit change.
- R8: A first-cycle write of 0x98 enters query mode. There a read at byte offset A[7:0] returns 0x51, 0x52 and 0x59 at offsets 0x10, 0x11 and 0x12, and 0x00 at every other offset.
- R9: While in query mode, a write of 0xFF returns to read-array mode, and any other byte leaves the block in query mode.
- R10: Any other first-cycle byte sets status bit 4 and selects read-array mode.
- R11: Error bits set in the status register persist through every fallback to read-array mode. Only the clear-status command or a reset clears them.
- R12: Bus cycles with chip select low, and read cycles, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | Write enable; a write needs cs_i high as well |
| addr_i | input | ADDR_W (10) | Byte address |
| wdata_i | input | 8 | Command or confirm byte |
| rdata_o | output | 8 | Read data from the source chosen by the mode |
| lock_o | output | N_BLK (4) | Lock bit of each block |

## Verification
The assertions check on every cycle that idle bus cycles and read cycles leave the command, counter and status unchanged, and that the counter is nonzero only while the lock command is armed. They also check that error bits survive every write other than a clear, and that a confirm always sets the ready bit. The bench's sweeps cover the rest. They drive every possible first-cycle byte and every possible second-cycle byte, then read the status back through the status command. They compare the whole array and the whole query window, and they replay chains of fallbacks to show the error bits persist. Only these scenarios can show which read source is selected after each command, and the array and query byte values.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_ARRAY2 = 8'hF0;
  localparam logic [7:0] CMD_CLRST  = 8'h50;
  localparam logic [7:0] CMD_RDST   = 8'h70;
  localparam logic [7:0] CMD_LOCK   = 8'h60;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CNF_LOCK   = 8'h01;
  localparam logic [7:0] CNF_UNLOCK = 8'hD0;

  localparam int ST_READY  = 7;
  localparam int ST_LKERR  = 5;
  localparam int ST_CMDERR = 4;

  localparam logic [7:0] QRY_BASE = 8'h10;
  localparam logic [7:0] ARR_MUL  = 8'd37;
  localparam logic [7:0] ARR_ADD  = 8'd11;
endpackage

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int CYC_W = 2,
  parameter int BLK_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [7:0]       cmd_o,
  output logic [CYC_W-1:0] wcyc_o,
  output logic [7:0]       status_o,
  output logic             lk_set_o,
  output logic             lk_clr_o,
  output logic [BLK_W-1:0] lk_idx_o
);
  logic [7:0]       cmd_q, cmd_d;
  logic [CYC_W-1:0] wcyc_q, wcyc_d;
  logic [7:0]       st_q, st_d;
  logic             set_c, clr_c;

  always_comb begin
    cmd_d  = cmd_q;
    wcyc_d = wcyc_q;
    st_d   = st_q;
    set_c  = 1'b0;
    clr_c  = 1'b0;
    if (wr_i) begin
      if (wcyc_q != '0) begin
        // second cycle of lock/unlock
        if (wdata_i == CNF_LOCK || wdata_i == CNF_UNLOCK) begin
          set_c          = (wdata_i == CNF_LOCK);
          clr_c          = (wdata_i == CNF_UNLOCK);
          st_d[ST_READY] = 1'b1;
          wcyc_d         = '0;
        end else begin
          if (wdata_i != CMD_ARRAY) st_d[ST_LKERR] = 1'b1;
          cmd_d  = CMD_ARRAY;
          wcyc_d = '0;
        end
      end else if (cmd_q == CMD_QUERY) begin
        if (wdata_i == CMD_ARRAY) cmd_d = CMD_ARRAY;
      end else begin
        unique case (wdata_i)
          CMD_ARRAY, CMD_ARRAY2: cmd_d = CMD_ARRAY;
          CMD_CLRST: begin
            st_d  = '0;
            cmd_d = CMD_ARRAY;
          end
          CMD_RDST:  cmd_d = CMD_RDST;
          CMD_QUERY: cmd_d = CMD_QUERY;
          CMD_LOCK: begin
            cmd_d  = CMD_LOCK;
            wcyc_d = wcyc_q + 1'b1;
          end
          default: begin
            st_d[ST_CMDERR] = 1'b1;
            cmd_d           = CMD_ARRAY;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_ARRAY;
      wcyc_q <= '0;
      st_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      wcyc_q <= wcyc_d;
      st_q   <= st_d;
    end
  end

  assign cmd_o    = cmd_q;
  assign wcyc_o   = wcyc_q;
  assign status_o = st_q;
  assign lk_set_o = set_c;
  assign lk_clr_o = clr_c;
  assign lk_idx_o = blk_i;

  logic first_clr;
  assign first_clr = wr_i && wcyc_q == '0 && cmd_q != CMD_QUERY && wdata_i == CMD_CLRST;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cmd_q) && $stable(wcyc_q) && $stable(st_q)); // R12
  AST_WCYC_ONLY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcyc_q != '0 |-> cmd_q == CMD_LOCK && wcyc_q == 1); // R6
  AST_CLR_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_clr |=> st_q == 8'h00 && cmd_q == CMD_ARRAY); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first_clr && (st_q[ST_CMDERR] || st_q[ST_LKERR]) |=>
      st_q[ST_CMDERR] >= $past(st_q[ST_CMDERR]) && st_q[ST_LKERR] >= $past(st_q[ST_LKERR])); // R11
  AST_CONFIRM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wcyc_q != '0 && (wdata_i == CNF_LOCK || wdata_i == CNF_UNLOCK) |=>
      st_q[ST_READY] && wcyc_q == '0 && cmd_q == CMD_LOCK); // R6
  AST_QUERY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && cmd_q == CMD_QUERY && wdata_i != CMD_ARRAY |=> cmd_q == CMD_QUERY); // R9
endmodule

// File: rtl/pflash_lock_bank.sv
module pflash_lock_bank #(
  parameter int N_BLK = 4,
  parameter int BLK_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] idx_i,
  output logic [N_BLK-1:0] lock_o
);
  logic [N_BLK-1:0] lock_q;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    logic hit;
    assign hit = (idx_i == BLK_W'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             lock_q[b] <= 1'b0;
      else if (hit && set_i)   lock_q[b] <= 1'b1;
      else if (hit && clr_i)   lock_q[b] <= 1'b0;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(lock_q)); // R7
  AST_LOCK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i)); // R6
endmodule

// File: rtl/pflash_read_mux.sv
module pflash_read_mux
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  input  logic [7:0]        status_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] a8, arr_b, qry_b;

  assign a8    = addr_i[7:0];
  assign arr_b = a8 * ARR_MUL + ARR_ADD;

  always_comb begin
    unique case (a8)
      QRY_BASE:         qry_b = 8'h51;
      QRY_BASE + 8'd1:  qry_b = 8'h52;
      QRY_BASE + 8'd2:  qry_b = 8'h59;
      default:          qry_b = 8'h00;
    endcase
  end

  always_comb begin
    if (cmd_i == CMD_ARRAY)      rdata_o = arr_b;
    else if (cmd_i == CMD_QUERY) rdata_o = qry_b;
    else                         rdata_o = status_i;
  end

  always_comb begin
    if (cmd_i == CMD_RDST || cmd_i == CMD_LOCK)
      AST_STATUS_SEL: assert (rdata_o == status_i); // R4
  end
endmodule

// File: rtl/pflash_cmd_ctrl.sv
module pflash_cmd_ctrl
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_BLK  = 4,
  parameter int CYC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [N_BLK-1:0]  lock_o
);
  localparam int BLK_W = $clog2(N_BLK);

  logic             wr;
  logic [7:0]       cmd, status;
  logic [CYC_W-1:0] wcyc;
  logic             lk_set, lk_clr;
  logic [BLK_W-1:0] lk_idx;

  assign wr = cs_i && we_i;

  pflash_seq #(.CYC_W(CYC_W), .BLK_W(BLK_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wdata_i  (wdata_i),
    .blk_i    (addr_i[ADDR_W-1 -: BLK_W]),
    .cmd_o    (cmd),
    .wcyc_o   (wcyc),
    .status_o (status),
    .lk_set_o (lk_set),
    .lk_clr_o (lk_clr),
    .lk_idx_o (lk_idx)
  );

  pflash_lock_bank #(.N_BLK(N_BLK), .BLK_W(BLK_W)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (lk_set),
    .clr_i  (lk_clr),
    .idx_i  (lk_idx),
    .lock_o (lock_o)
  );

  pflash_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
    .addr_i   (addr_i),
    .cmd_i    (cmd),
    .status_i (status),
    .rdata_o  (rdata_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> cmd == CMD_ARRAY && status == 8'h00 && lock_o == '0); // R1
  AST_LOCK_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(lock_o)); // R12
endmodule

// File: tb/pflash_cmd_ctrl_test.sv
module pflash_cmd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] lock;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] exp_lock = '0;

  always #2 clk = ~clk;

  pflash_cmd_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .lock_o(lock)
  );

  function automatic logic [7:0] arr_exp(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  function automatic logic [7:0] qry_exp(input int a);
    case (a % 256)
      16: return 8'h51;
      17: return 8'h52;
      18: return 8'h59;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 10'(a); wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = 10'(a); wdata = 8'h50;
    #1 v = rdata;
  endtask

  task automatic status_chk(input string tag, input int exp);
    logic [7:0] v;
    wr(0, 8'h70);
    rd(0, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3, v);
    chk("R1 array after reset", v, arr_exp(3));
    chk("R1 locks after reset", lock, 0);
    status_chk("R1 status after reset", 8'h00);
    wr(0, 8'hFF);

    // R2 full array sweep
    for (int a = 0; a < 1024; a++) begin
      rd(a, v);
      chk("R2 array byte", v, arr_exp(a));
    end

    // R8 query sweep, R9 non-FF writes keep query
    wr(0, 8'h98);
    for (int a = 0; a < 256; a++) begin
      rd(a + 256 * (a % 4), v);
      chk("R8 query byte", v, qry_exp(a));
    end
    wr(0, 8'h50); wr(0, 8'h60); wr(0, 8'h00);
    rd(17, v);
    chk("R9 query held", v, 8'h52);
    wr(0, 8'hFF);
    rd(17, v);
    chk("R9 query exit", v, arr_exp(17));

    // first-cycle sweep: R3 R4 R5 R8 R10
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      logic       unk;
      int         exp_rd;
      cb = 8'(c);
      wr(0, 8'h50);
      wr(0, cb);
      unk = !(cb inside {8'hFF, 8'hF0, 8'h50, 8'h70, 8'h60, 8'h98});
      if (cb == 8'h98) exp_rd = 8'h51;
      else if (cb == 8'h70 || cb == 8'h60) exp_rd = 0;
      else exp_rd = arr_exp(16);
      rd(16, v);
      chk("R10/R3/R4/R5/R8 mode after first byte", v, exp_rd);
      if (cb == 8'h60 || cb == 8'h98) wr(0, 8'hFF);
      status_chk("R10 status after first byte", unk ? 8'h10 : 8'h00);
    end

    // second-cycle sweep: R6 R7
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      int         a, st, exp_rd;
      cb = 8'(c);
      a  = (c % 4) * 256 + 8'h23;
      wr(0, 8'h50);
      wr(a, 8'h60);
      wr(a, cb);
      if (cb == 8'h01) exp_lock[c % 4] = 1'b1;
      if (cb == 8'hD0) exp_lock[c % 4] = 1'b0;
      if (cb == 8'h01 || cb == 8'hD0) begin st = 8'h80; exp_rd = 8'h80; end
      else if (cb == 8'hFF) begin st = 0; exp_rd = arr_exp(a); end
      else begin st = 8'h20; exp_rd = arr_exp(a); end
      rd(a, v);
      chk("R6/R7 read after confirm", v, exp_rd);
      chk("R6/R7 lock bits", lock, exp_lock);
      status_chk("R6/R7 status after confirm", st);
    end
    // lock and unlock every block
    for (int b = 0; b < 4; b++) begin
      wr(b * 256, 8'h60); wr(b * 256, 8'h01);
      exp_lock[b] = 1'b1;
      chk("R6 lock block", lock, exp_lock);
    end
    for (int b = 0; b < 4; b++) begin
      wr(b * 256 + 5, 8'h60); wr(b * 256 + 5, 8'hD0);
      exp_lock[b] = 1'b0;
      chk("R6 unlock block", lock, exp_lock);
    end

    // R11 sticky error bits through fallbacks
    wr(0, 8'h50);
    wr(0, 8'h00);
    wr(0, 8'hFF); wr(0, 8'hF0);
    wr(0, 8'h98); wr(0, 8'hFF);
    wr(0, 8'h60); wr(0, 8'hFF);
    wr(0, 8'h60); wr(0, 8'h42);
    status_chk("R11 errors persist", 8'h30);
    wr(0, 8'h60); wr(0, 8'h50);
    status_chk("R11 clear on second cycle is no clear", 8'h30);

    // R12 deselected writes and reads change nothing
    @(negedge clk);
    cs = 1'b0; we = 1'b1; wdata = 8'h50;
    @(negedge clk);
    cs = 1'b0; we = 1'b1; wdata = 8'hFF;
    @(negedge clk);
    we = 1'b0;
    rd(0, v);
    chk("R12 status after deselected writes", v, 8'h30);
    @(negedge clk);
    cs = 1'b0; we = 1'b1; addr = 10'h100; wdata = 8'h60;
    @(negedge clk);
    wdata = 8'h01;
    @(negedge clk);
    we = 1'b0;
    chk("R12 locks after deselected writes", lock, 0);
    wr(0, 8'h50);
    status_chk("R5 cleared", 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule